// File: doc/BRIEF.md
# Host Address Window Decoder

This block sits on the host side of a serial peripheral link and decides, for every host I/O or memory cycle, whether that cycle belongs to the one peripheral behind the link. It holds a bank of programmable I/O windows and a bank of programmable memory windows. Each window has a base register, a length-minus-one size register and its own enable bit. It also has three fixed legacy-port decodes and a subtractive fallback that claims any cycle no positive decode took.

Software programs the windows through a simple register write/read port. The request side presents one cycle per clock (type and address). One clock later the block reports whether the cycle is claimed, and whether the claim came only from the subtractive fallback.

Top module: `hwin_decoder`

## Requirements
- R1: After a synchronous reset, every register reads back 0 and no I/O or memory cycle is claimed.
- R2: An enabled I/O window claims an I/O cycle when base <= addr[15:0] <= base + size. The size field holds length minus one, so a stored 0 covers exactly one port.
- R3: A window whose enable bit is 0 claims nothing, whatever its base and size hold. Its base and size registers keep their values.
- R4: The enable bits are split into two groups of G (default 4) windows. Register 0x01 holds windows 0..G-1 and register 0x02 holds windows G..2G-1. In each group, I/O window offset k is bit k and memory window offset k is bit 8+k.
- R5: An enabled memory window uses a 32-bit base at 0x20+i and a 16-bit size at 0x30+i[15:0]. It claims memory cycles with base <= addr <= base + size.
- R6: Control register 0x00 bit0 claims I/O port 0x80. Bit1 claims ports 0x60 and 0x64, but not the ports between them. Bit2 claims ports 0x2E and 0x2F. None of these uses a generic window.
- R7: I/O windows and fixed decodes never claim memory cycles, and memory windows never claim I/O cycles.
- R8: With control bit3 set, a cycle that no positive decode claims is still claimed with claim_sub=1. A positively decoded cycle always has claim_sub=0.
- R9: claim_valid, claim and claim_sub are registered and appear one clock after the request. With no request, all three are 0.
- R10: I/O window register 0x10+i reads as {size[7:0] in bits 23:16, base in bits 15:0}. Reads return data one clock after cfg_re.
- R11: A window end never wraps. For example, an I/O window at 0xFFFF with size 0xFF covers only port 0xFFFF and not port 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the clock after cfg_re |
| req_valid | input | 1 | Cycle request present |
| req_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_addr | input | 32 | Cycle address (I/O uses bits 15:0) |
| claim_valid | output | 1 | Result present |
| claim | output | 1 | Cycle is claimed for the peripheral |
| claim_sub | output | 1 | Claim came only from the subtractive fallback |

## Verification
The bench probes both edges of every window, one below the base and one past the end. A design that treats the size field as a length rather than length minus one would drop the top port or miss a one-port window. It puts a window at the top of the I/O space, where a wrapping end computation would claim port 0. It enables an extended-group bit next to the wanted one, which would expose a group or offset mapping error. It also sends memory cycles to fixed-port addresses and I/O cycles to windowed memory bases, which would expose a missing type qualification. The subtractive runs check that a positive hit never reports claim_sub, which a design with the priority reversed would do.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_EN0  = 8'h01;
  localparam logic [7:0] A_EN1  = 8'h02;
  localparam logic [3:0] A_IOW  = 4'h1;
  localparam logic [3:0] A_MBASE = 4'h2;
  localparam logic [3:0] A_MSIZE = 4'h3;

  localparam int CTL_POST = 0;
  localparam int CTL_KBC  = 1;
  localparam int CTL_CFG  = 2;
  localparam int CTL_SUB  = 3;
  localparam int MEM_EN_LSB = 8;
  localparam int IO_SZ_LSB  = 16;

  localparam logic [15:0] P_POST     = 16'h0080;
  localparam logic [15:0] P_KBC_DATA = 16'h0060;
  localparam logic [15:0] P_KBC_CMD  = 16'h0064;
  localparam logic [15:0] P_CFG_IDX  = 16'h002E;
  localparam logic [15:0] P_CFG_DAT  = 16'h002F;
endpackage

// File: rtl/hwin_range_match.sv
module hwin_range_match #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] size_m1,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [AW:0] last;
  always_comb begin
    last = {1'b0, base} + (AW+1)'(size_m1);
    hit  = en && (addr >= base) && ({1'b0, addr} <= last);
  end
endmodule

// File: rtl/hwin_fixed_decode.sv
module hwin_fixed_decode
  import hwin_pkg::*;
(
  input  logic        is_io,
  input  logic [15:0] port,
  input  logic [2:0]  fix_en,
  output logic        hit
);
  logic post_hit, kbc_hit, cfg_hit;
  always_comb begin
    post_hit = fix_en[CTL_POST] && (port == P_POST);
    kbc_hit  = fix_en[CTL_KBC]  && ((port == P_KBC_DATA) || (port == P_KBC_CMD));
    cfg_hit  = fix_en[CTL_CFG]  && ((port == P_CFG_IDX) || (port == P_CFG_DAT));
    hit      = is_io && (post_hit || kbc_hit || cfg_hit);
  end
endmodule

// File: rtl/hwin_regs.sv
module hwin_regs
  import hwin_pkg::*;
#(
  parameter int N_IO   = 8,
  parameter int N_MEM  = 6,
  parameter int GRP    = 4,
  parameter int IO_AW  = 16,
  parameter int IO_SW  = 8,
  parameter int MEM_AW = 32,
  parameter int MEM_SW = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic                          re,
  input  logic [7:0]                    addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output logic [N_IO-1:0][IO_AW-1:0]    io_base,
  output logic [N_IO-1:0][IO_SW-1:0]    io_size,
  output logic [N_MEM-1:0][MEM_AW-1:0]  mem_base,
  output logic [N_MEM-1:0][MEM_SW-1:0]  mem_size,
  output logic [N_IO-1:0]               io_en,
  output logic [N_MEM-1:0]              mem_en,
  output logic [2:0]                    fix_en,
  output logic                          sub_en
);
  logic [31:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      io_base <= '0; io_size <= '0; mem_base <= '0; mem_size <= '0;
      io_en <= '0; mem_en <= '0; fix_en <= '0; sub_en <= 1'b0;
    end else if (we) begin
      if (addr == A_CTRL) begin
        fix_en <= wdata[2:0];
        sub_en <= wdata[CTL_SUB];
      end
      for (int i = 0; i < N_IO; i++) begin
        if (addr == A_EN0 && i < GRP)  io_en[i] <= wdata[i];
        if (addr == A_EN1 && i >= GRP) io_en[i] <= wdata[i-GRP];
        if (addr[7:4] == A_IOW && addr[3:0] == 4'(i)) begin
          io_base[i] <= wdata[IO_AW-1:0];
          io_size[i] <= wdata[IO_SZ_LSB +: IO_SW];
        end
      end
      for (int i = 0; i < N_MEM; i++) begin
        if (addr == A_EN0 && i < GRP)  mem_en[i] <= wdata[MEM_EN_LSB+i];
        if (addr == A_EN1 && i >= GRP) mem_en[i] <= wdata[MEM_EN_LSB+i-GRP];
        if (addr[7:4] == A_MBASE && addr[3:0] == 4'(i)) mem_base[i] <= wdata[MEM_AW-1:0];
        if (addr[7:4] == A_MSIZE && addr[3:0] == 4'(i)) mem_size[i] <= wdata[MEM_SW-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == A_CTRL) rd_next = {28'd0, sub_en, fix_en};
    for (int i = 0; i < N_IO; i++) begin
      if (addr == A_EN0 && i < GRP)  rd_next[i] = io_en[i];
      if (addr == A_EN1 && i >= GRP) rd_next[i-GRP] = io_en[i];
      if (addr[7:4] == A_IOW && addr[3:0] == 4'(i)) begin
        rd_next[IO_AW-1:0] = io_base[i];
        rd_next[IO_SZ_LSB +: IO_SW] = io_size[i];
      end
    end
    for (int i = 0; i < N_MEM; i++) begin
      if (addr == A_EN0 && i < GRP)  rd_next[MEM_EN_LSB+i] = mem_en[i];
      if (addr == A_EN1 && i >= GRP) rd_next[MEM_EN_LSB+i-GRP] = mem_en[i];
      if (addr[7:4] == A_MBASE && addr[3:0] == 4'(i)) rd_next[MEM_AW-1:0] = mem_base[i];
      if (addr[7:4] == A_MSIZE && addr[3:0] == 4'(i)) rd_next[MEM_SW-1:0] = mem_size[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_next;
  end
endmodule

// File: rtl/hwin_decoder.sv
module hwin_decoder #(
  parameter int N_IO   = 8,
  parameter int N_MEM  = 6,
  parameter int GRP    = 4,
  parameter int IO_AW  = 16,
  parameter int IO_SW  = 8,
  parameter int MEM_AW = 32,
  parameter int MEM_SW = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic        cfg_re,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic        req_is_mem,
  input  logic [31:0] req_addr,
  output logic        claim_valid,
  output logic        claim,
  output logic        claim_sub
);
  logic [N_IO-1:0][IO_AW-1:0]   io_base;
  logic [N_IO-1:0][IO_SW-1:0]   io_size;
  logic [N_MEM-1:0][MEM_AW-1:0] mem_base;
  logic [N_MEM-1:0][MEM_SW-1:0] mem_size;
  logic [N_IO-1:0]              io_en;
  logic [N_MEM-1:0]             mem_en;
  logic [2:0]                   fix_en;
  logic                         sub_en;
  logic [N_IO-1:0]              io_hit;
  logic [N_MEM-1:0]             mem_hit;
  logic                         fix_hit;
  logic                         pos_hit;

  hwin_regs #(
    .N_IO(N_IO), .N_MEM(N_MEM), .GRP(GRP), .IO_AW(IO_AW),
    .IO_SW(IO_SW), .MEM_AW(MEM_AW), .MEM_SW(MEM_SW)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .re(cfg_re), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .io_base(io_base), .io_size(io_size), .mem_base(mem_base), .mem_size(mem_size),
    .io_en(io_en), .mem_en(mem_en), .fix_en(fix_en), .sub_en(sub_en)
  );

  for (genvar i = 0; i < N_IO; i++) begin : g_io
    hwin_range_match #(.AW(IO_AW), .SW(IO_SW)) u_match (
      .en(io_en[i] && !req_is_mem), .base(io_base[i]), .size_m1(io_size[i]),
      .addr(req_addr[IO_AW-1:0]), .hit(io_hit[i])
    );
  end

  for (genvar i = 0; i < N_MEM; i++) begin : g_mem
    hwin_range_match #(.AW(MEM_AW), .SW(MEM_SW)) u_match (
      .en(mem_en[i] && req_is_mem), .base(mem_base[i]), .size_m1(mem_size[i]),
      .addr(req_addr[MEM_AW-1:0]), .hit(mem_hit[i])
    );
  end

  hwin_fixed_decode u_fixed (
    .is_io(!req_is_mem), .port(req_addr[15:0]), .fix_en(fix_en), .hit(fix_hit)
  );

  assign pos_hit = (|io_hit) || (|mem_hit) || fix_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_valid <= 1'b0;
      claim       <= 1'b0;
      claim_sub   <= 1'b0;
    end else begin
      claim_valid <= req_valid;
      claim       <= req_valid && (pos_hit || sub_en);
      claim_sub   <= req_valid && !pos_hit && sub_en;
    end
  end
endmodule

// File: rtl/hwin_decoder_chk.sv
module hwin_decoder_chk #(
  parameter int N_IO  = 8,
  parameter int N_MEM = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             claim_valid,
  input logic             claim,
  input logic             claim_sub,
  input logic             sub_en,
  input logic [2:0]       fix_en,
  input logic [N_IO-1:0]  io_en,
  input logic [N_MEM-1:0] mem_en
);
  a_r9_result_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> claim_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!claim_valid && !claim && !claim_sub));
  a_r8_sub_implies_claim: assert property (@(posedge clk) disable iff (rst)
    claim_sub |-> claim);
  a_r8_sub_needs_enable: assert property (@(posedge clk) disable iff (rst)
    claim_sub |-> $past(sub_en));
  a_r3_all_disabled_no_claim: assert property (@(posedge clk) disable iff (rst)
    (!$past(sub_en) && $past(fix_en) == 3'b000 && $past(io_en) == '0 && $past(mem_en) == '0)
      |-> !claim);
endmodule

bind hwin_decoder hwin_decoder_chk #(.N_IO(N_IO), .N_MEM(N_MEM)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .claim_valid(claim_valid),
  .claim(claim), .claim_sub(claim_sub), .sub_en(sub_en), .fix_en(fix_en),
  .io_en(io_en), .mem_en(mem_en)
);

// File: tb/hwin_decoder_test.sv
module hwin_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_is_mem = 1'b0;
  logic [31:0] req_addr = '0;
  logic        claim_valid, claim, claim_sub;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { logic c; logic s; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  hwin_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_is_mem(req_is_mem), .req_addr(req_addr), .claim_valid(claim_valid),
    .claim(claim), .claim_sub(claim_sub)
  );

  // monitor: pops one expected item per produced result
  always @(negedge clk) begin
    if (!rst && claim_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R9: unexpected result claim=%0b sub=%0b expected none", claim, claim_sub);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (claim !== e.c || claim_sub !== e.s) begin
          bad++;
          $display("FAIL %s: claim=%0b sub=%0b expected claim=%0b sub=%0b",
                   e.tag, claim, claim_sub, e.c, e.s);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 0; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    req_valid = 0; cfg_re = 1; cfg_addr = a;
    @(posedge clk); #1;
    cfg_re = 0;
    total++;
    if (cfg_rdata !== e) begin
      bad++;
      $display("FAIL %s: reg %h read %h expected %h", tag, a, cfg_rdata, e);
    end
  endtask

  task automatic send(input logic m, input logic [31:0] a, input logic c, input logic s,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1; req_is_mem = m; req_addr = a;
    e.c = c; e.s = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_chk();
    @(posedge clk); #1;
    req_valid = 0;
    @(posedge clk); #1;
    total++;
    if (claim_valid !== 1'b0 || claim !== 1'b0) begin
      bad++;
      $display("FAIL R9: idle valid=%0b claim=%0b expected 0 0", claim_valid, claim);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R1 / R10: reset state
    rd_chk(8'h00, 32'h0, "R1");
    rd_chk(8'h01, 32'h0, "R1");
    rd_chk(8'h02, 32'h0, "R1");
    rd_chk(8'h13, 32'h0, "R1");
    rd_chk(8'h20, 32'h0, "R1");
    rd_chk(8'h35, 32'h0, "R1");
    send(0, 32'h80, 0, 0, "R1");
    send(1, 32'h0, 0, 0, "R1");
    idle_chk();

    // R3 then R2: one-port window at 0x400
    wr(8'h10, 32'h0000_0400);
    send(0, 32'h400, 0, 0, "R3");
    wr(8'h01, 32'h1);
    send(0, 32'h400, 1, 0, "R2");
    send(0, 32'h401, 0, 0, "R2");
    send(0, 32'h3FF, 0, 0, "R2");
    idle_chk();

    // R4: window 5 is extended group offset 1
    wr(8'h15, 32'h000F_0A00);
    wr(8'h02, 32'h1);
    send(0, 32'hA00, 0, 0, "R4");
    wr(8'h02, 32'h2);
    send(0, 32'hA00, 1, 0, "R4");
    send(0, 32'hA0F, 1, 0, "R4");
    send(0, 32'hA10, 0, 0, "R4");
    rd_chk(8'h02, 32'h2, "R4");

    // R11: no wrap at top of I/O space
    wr(8'h11, 32'h00FF_FFFF);
    wr(8'h01, 32'h3);
    send(0, 32'hFFFF, 1, 0, "R11");
    send(0, 32'h0000, 0, 0, "R11");
    rd_chk(8'h11, 32'h00FF_FFFF, "R10");

    // R5 / R7: memory windows
    wr(8'h20, 32'hFED0_0000);
    wr(8'h30, 32'h0000_FFFF);
    wr(8'h01, 32'h103);
    send(1, 32'hFED0_FFFF, 1, 0, "R5");
    send(1, 32'hFED1_0000, 0, 0, "R5");
    send(1, 32'hFECF_FFFF, 0, 0, "R5");
    send(1, 32'h0000_0400, 0, 0, "R7");
    send(0, 32'hFED0_0400, 1, 0, "R7");
    send(0, 32'h0000_0000, 0, 0, "R7");
    wr(8'h25, 32'h1000_0000);
    wr(8'h02, 32'h202);
    send(1, 32'h1000_0000, 1, 0, "R4");
    send(1, 32'h1000_0001, 0, 0, "R5");
    rd_chk(8'h01, 32'h103, "R10");
    idle_chk();

    // R6 / R7: fixed legacy ports
    wr(8'h00, 32'h1);
    send(0, 32'h80, 1, 0, "R6");
    send(0, 32'h60, 0, 0, "R6");
    wr(8'h00, 32'h7);
    send(0, 32'h60, 1, 0, "R6");
    send(0, 32'h64, 1, 0, "R6");
    send(0, 32'h61, 0, 0, "R6");
    send(0, 32'h2E, 1, 0, "R6");
    send(0, 32'h2F, 1, 0, "R6");
    send(0, 32'h30, 0, 0, "R6");
    send(0, 32'h81, 0, 0, "R6");
    send(1, 32'h80, 0, 0, "R7");

    // R8: subtractive fallback and priority
    wr(8'h00, 32'h8);
    send(0, 32'h1234, 1, 1, "R8");
    send(0, 32'h400, 1, 0, "R8");
    send(1, 32'h5, 1, 1, "R8");
    send(0, 32'h80, 1, 1, "R8");
    rd_chk(8'h00, 32'h8, "R10");

    // R3: disable all, registers retained
    wr(8'h00, 32'h0);
    wr(8'h01, 32'h0);
    wr(8'h02, 32'h0);
    send(0, 32'h400, 0, 0, "R3");
    send(1, 32'hFED0_0000, 0, 0, "R3");
    send(0, 32'hA00, 0, 0, "R3");
    rd_chk(8'h10, 32'h0000_0400, "R3");
    rd_chk(8'h30, 32'h0000_FFFF, "R3");
    idle_chk();

    repeat (3) @(posedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9: %0d results missing, expected 0", q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule